// File: doc/BRIEF.md
# Branch Misprediction Redirect Unit

This unit sits in the execute stage of an in-order pipeline. Each cycle it may receive one resolved control-transfer instruction. It gets the direction and target that the fetch stage guessed, and the direction and target that execute computed. When the guess was wrong, the unit raises a one-cycle flush for the two front pipeline registers (fetch/decode and decode/execute). In the same cycle it drives a redirect strobe carrying the corrected fetch address. The flush and the redirect appear one clock after the instruction was presented.

The corrected address is the execute-computed target when the branch is actually taken. When it is not taken, the corrected address is the instruction's own address plus the instruction size. The unit also produces two registered enables for the predictor tables. One fires for every resolved branch or jump, so the direction counters can learn. The other fires only for those actually taken, so the target buffer can be written.

A two-state machine controls the timing. In state `ST_RUN` the unit accepts its input. An accepted mispredict moves it to state `ST_REDIRECT` for exactly one cycle, and there it drives flush and redirect. While in `ST_REDIRECT`, the execute slot holds a wrong-path instruction, so that cycle's input is discarded. The machine then always returns to `ST_RUN`. Input is therefore accepted only when valid is high and the machine is in `ST_RUN`.

Top module: `br_redirect_unit`

## Requirements
- R1: An instruction whose branch/jump flag is low never causes a flush or a redirect, and never raises either table-update enable, whatever its prediction fields hold.
- R2: An accepted branch whose predicted direction differs from its resolved direction raises `flush_front_o` and `redirect_valid_o` in the next cycle.
- R3: An accepted branch that is both predicted and resolved taken mispredicts exactly when the predicted target differs from the computed target. A branch both predicted and resolved not-taken never mispredicts, whatever its target fields hold.
- R4: On a mispredict whose resolved direction is taken, `redirect_pc_o` equals the computed target.
- R5: On a mispredict whose resolved direction is not taken, `redirect_pc_o` equals the instruction PC plus INSN_BYTES (4 by default), wrapping modulo 2^XLEN.
- R6: `flush_front_o` and `redirect_valid_o` are always equal. Each is high for exactly one cycle per mispredict. `redirect_pc_o` is zero whenever `redirect_valid_o` is low.
- R7: When `ex_valid_i` is low, no flush, redirect or update enable results in the next cycle.
- R8: `dir_upd_en_o` is high in the cycle after every accepted branch or jump, whether or not it mispredicted.
- R9: `tgt_upd_en_o` is high in the cycle after every accepted branch or jump that resolved taken, and is never high without `dir_upd_en_o`.
- R10: Input presented in a cycle where `flush_front_o` is high is ignored: the next cycle shows no flush, no redirect and no update enable.
- R11: After reset, with no input yet accepted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ex_valid_i | input | 1 | An instruction occupies the execute slot |
| ex_is_cti_i | input | 1 | That instruction is a branch or jump |
| pred_taken_i | input | 1 | Direction guessed at fetch |
| pred_target_i | input | XLEN | Target guessed at fetch |
| act_taken_i | input | 1 | Direction resolved in execute |
| act_target_i | input | XLEN | Target computed in execute |
| ex_pc_i | input | XLEN | Address of the instruction |
| flush_front_o | output | 1 | Invalidate both front pipeline registers |
| redirect_valid_o | output | 1 | Fetch must load `redirect_pc_o` |
| redirect_pc_o | output | XLEN | Corrected fetch address |
| dir_upd_en_o | output | 1 | Write enable for the direction table |
| tgt_upd_en_o | output | 1 | Write enable for the target buffer |

## Verification
The bench uses the defaults XLEN = 32 and INSN_BYTES = 4. With these values, a directed case at PC 0xFFFFFFFC reaches the wrap of the sequential address to zero. Random targets are drawn to agree half the time, so both taken-target outcomes of R3 occur often. Valid is held high on most cycles, so random runs produce frequent back-to-back mispredicts and exercise the discard rule of R10 many times.

// File: rtl/br_redirect_pkg.sv
package br_redirect_pkg;

    typedef enum logic [0:0] {
        ST_RUN      = 1'b0,
        ST_REDIRECT = 1'b1
    } redir_state_e;

endpackage

// File: rtl/br_outcome_cmp.sv
module br_outcome_cmp #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            is_cti_i,
    input  logic            pred_taken_i,
    input  logic [XLEN-1:0] pred_target_i,
    input  logic            act_taken_i,
    input  logic [XLEN-1:0] act_target_i,
    input  logic [XLEN-1:0] pc_i,
    output logic            mispredict_o,
    output logic [XLEN-1:0] fix_pc_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic dir_wrong;
    logic tgt_wrong;

    always_comb begin
        dir_wrong    = pred_taken_i != act_taken_i;
        tgt_wrong    = pred_taken_i && act_taken_i && (pred_target_i != act_target_i);
        mispredict_o = is_cti_i && (dir_wrong || tgt_wrong);
        fix_pc_o     = act_taken_i ? act_target_i : (pc_i + STEP);
    end
endmodule

// File: rtl/br_redirect_fsm.sv
module br_redirect_fsm
    import br_redirect_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            valid_i,
    input  logic            mispredict_i,
    input  logic [XLEN-1:0] fix_pc_i,
    output logic            accept_o,
    output logic            flush_o,
    output logic            redir_valid_o,
    output logic [XLEN-1:0] redir_pc_o
);
    redir_state_e    state_q;
    redir_state_e    state_d;
    logic [XLEN-1:0] pc_q;

    always_comb begin
        accept_o = valid_i && (state_q == ST_RUN);
        state_d  = state_q;
        unique case (state_q)
            ST_RUN:      if (accept_o && mispredict_i) state_d = ST_REDIRECT;
            ST_REDIRECT: state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept_o && mispredict_i) pc_q <= fix_pc_i;
        end
    end

    always_comb begin
        flush_o       = 1'b0;
        redir_valid_o = 1'b0;
        redir_pc_o    = '0;
        unique case (state_q)
            ST_RUN: ;
            ST_REDIRECT: begin
                flush_o       = 1'b1;
                redir_valid_o = 1'b1;
                redir_pc_o    = pc_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/br_update_gen.sv
module br_update_gen (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic accept_i,
    input  logic is_cti_i,
    input  logic act_taken_i,
    output logic dir_en_o,
    output logic tgt_en_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dir_en_o <= 1'b0;
            tgt_en_o <= 1'b0;
        end else begin
            dir_en_o <= accept_i && is_cti_i;
            tgt_en_o <= accept_i && is_cti_i && act_taken_i;
        end
    end
endmodule

// File: rtl/br_redirect_unit.sv
module br_redirect_unit #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ex_valid_i,
    input  logic            ex_is_cti_i,
    input  logic            pred_taken_i,
    input  logic [XLEN-1:0] pred_target_i,
    input  logic            act_taken_i,
    input  logic [XLEN-1:0] act_target_i,
    input  logic [XLEN-1:0] ex_pc_i,
    output logic            flush_front_o,
    output logic            redirect_valid_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            dir_upd_en_o,
    output logic            tgt_upd_en_o
);
    logic            mispredict;
    logic [XLEN-1:0] fix_pc;
    logic            accept;

    br_outcome_cmp #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) cmp_i (
        .is_cti_i      (ex_is_cti_i),
        .pred_taken_i  (pred_taken_i),
        .pred_target_i (pred_target_i),
        .act_taken_i   (act_taken_i),
        .act_target_i  (act_target_i),
        .pc_i          (ex_pc_i),
        .mispredict_o  (mispredict),
        .fix_pc_o      (fix_pc)
    );

    br_redirect_fsm #(.XLEN(XLEN)) fsm_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .valid_i       (ex_valid_i),
        .mispredict_i  (mispredict),
        .fix_pc_i      (fix_pc),
        .accept_o      (accept),
        .flush_o       (flush_front_o),
        .redir_valid_o (redirect_valid_o),
        .redir_pc_o    (redirect_pc_o)
    );

    br_update_gen upd_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .accept_i    (accept),
        .is_cti_i    (ex_is_cti_i),
        .act_taken_i (act_taken_i),
        .dir_en_o    (dir_upd_en_o),
        .tgt_en_o    (tgt_upd_en_o)
    );
endmodule

// File: rtl/br_redirect_chk.sv
module br_redirect_chk #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            ex_valid_i,
    input logic            ex_is_cti_i,
    input logic            pred_taken_i,
    input logic            act_taken_i,
    input logic [XLEN-1:0] act_target_i,
    input logic [XLEN-1:0] ex_pc_i,
    input logic            flush_front_o,
    input logic            redirect_valid_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic            dir_upd_en_o,
    input logic            tgt_upd_en_o
);
    a_r1_no_flush_non_cti: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ex_valid_i && !ex_is_cti_i && !flush_front_o) |=> (!flush_front_o && !dir_upd_en_o));

    a_r4_taken_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ex_valid_i && ex_is_cti_i && act_taken_i && !pred_taken_i && !flush_front_o)
        |=> (flush_front_o && redirect_pc_o == $past(act_target_i)));

    a_r5_seq_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ex_valid_i && ex_is_cti_i && !act_taken_i && pred_taken_i && !flush_front_o)
        |=> (flush_front_o && redirect_pc_o == $past(ex_pc_i) + XLEN'(INSN_BYTES)));

    a_r6_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_front_o == redirect_valid_o);

    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_front_o |=> !flush_front_o);

    a_r6_pc_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !redirect_valid_o |-> (redirect_pc_o == '0));

    a_r7_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ex_valid_i |=> (!flush_front_o && !dir_upd_en_o));

    a_r8_dir_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ex_valid_i && ex_is_cti_i && !flush_front_o) |=> dir_upd_en_o);

    a_r9_tgt_implies_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tgt_upd_en_o |-> dir_upd_en_o);

    a_r10_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_front_o |=> (!dir_upd_en_o && !tgt_upd_en_o && !redirect_valid_o));
endmodule

bind br_redirect_unit br_redirect_chk #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) chk_i (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .ex_valid_i       (ex_valid_i),
    .ex_is_cti_i      (ex_is_cti_i),
    .pred_taken_i     (pred_taken_i),
    .act_taken_i      (act_taken_i),
    .act_target_i     (act_target_i),
    .ex_pc_i          (ex_pc_i),
    .flush_front_o    (flush_front_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .dir_upd_en_o     (dir_upd_en_o),
    .tgt_upd_en_o     (tgt_upd_en_o)
);

// File: tb/br_redirect_unit_tb_top.sv
`timescale 1ns/1ps
module br_redirect_unit_tb_top;
    localparam int XLEN       = 32;
    localparam int INSN_BYTES = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            v = 1'b0, br = 1'b0, pt = 1'b0, at = 1'b0;
    logic [XLEN-1:0] ptg = '0, atg = '0, pc = '0;
    logic            flush, rvalid, dir_en, tgt_en;
    logic [XLEN-1:0] rpc;

    int checks = 0;
    int errors = 0;
    logic m_flush = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    br_redirect_unit #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ex_valid_i(v), .ex_is_cti_i(br),
        .pred_taken_i(pt), .pred_target_i(ptg), .act_taken_i(at),
        .act_target_i(atg), .ex_pc_i(pc), .flush_front_o(flush),
        .redirect_valid_o(rvalid), .redirect_pc_o(rpc),
        .dir_upd_en_o(dir_en), .tgt_upd_en_o(tgt_en)
    );

    task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic exp_miss(logic acc, logic b, logic p, logic a,
                                      logic [XLEN-1:0] pg, logic [XLEN-1:0] ag);
        return acc && b && ((p != a) || (p && a && pg != ag));
    endfunction

    task automatic step(string req, logic iv, logic ib, logic ip, logic [XLEN-1:0] ipg,
                        logic ia, logic [XLEN-1:0] iag, logic [XLEN-1:0] ipc);
        logic            acc, ef, ed, et;
        logic [XLEN-1:0] ep;
        acc = iv && !m_flush;
        ef  = exp_miss(acc, ib, ip, ia, ipg, iag);
        ep  = ef ? (ia ? iag : ipc + XLEN'(INSN_BYTES)) : '0;
        ed  = acc && ib;
        et  = acc && ib && ia;
        v = iv; br = ib; pt = ip; ptg = ipg; at = ia; atg = iag; pc = ipc;
        @(posedge clk);
        @(negedge clk);
        chk({req, " flush"}, XLEN'(flush), XLEN'(ef));
        chk({req, " R6 redirect_valid"}, XLEN'(rvalid), XLEN'(ef));
        chk({req, " redirect_pc"}, rpc, ep);
        chk({req, " R8 dir_en"}, XLEN'(dir_en), XLEN'(ed));
        chk({req, " R9 tgt_en"}, XLEN'(tgt_en), XLEN'(et));
        m_flush = ef;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R11 flush", XLEN'(flush), '0);
        chk("R11 redirect_valid", XLEN'(rvalid), '0);
        chk("R11 redirect_pc", rpc, '0);
        chk("R11 dir_en", XLEN'(dir_en), '0);
        chk("R11 tgt_en", XLEN'(tgt_en), '0);
        rst_n = 1'b1;
        @(negedge clk);

        step("R1",  1, 0, 1, 32'h100, 0, 32'h200, 32'h1000);
        step("R7",  0, 1, 0, 32'h100, 1, 32'h200, 32'h1000);
        step("R2_R4", 1, 1, 0, 32'h0, 1, 32'h4000, 32'h1000);
        step("R6",  0, 0, 0, 32'h0, 0, 32'h0, 32'h0);
        step("R2_R5", 1, 1, 1, 32'h4000, 0, 32'h4000, 32'h2000);
        step("R6",  0, 0, 0, 32'h0, 0, 32'h0, 32'h0);
        step("R5_wrap", 1, 1, 1, 32'h10, 0, 32'h10, 32'hFFFF_FFFC);
        step("R6",  0, 0, 0, 32'h0, 0, 32'h0, 32'h0);
        step("R3_tgt_diff", 1, 1, 1, 32'h5000, 1, 32'h5008, 32'h3000);
        step("R3_tgt_same", 1, 1, 1, 32'h5008, 1, 32'h5008, 32'h3000);
        step("R3_nt_nt", 1, 1, 0, 32'h1, 0, 32'h9, 32'h3004);
        step("R2_first", 1, 1, 0, 32'h0, 1, 32'h6000, 32'h3008);
        step("R10_squash", 1, 1, 1, 32'h7000, 0, 32'h7000, 32'h300C);
        step("R10_after", 1, 1, 0, 32'h0, 0, 32'h0, 32'h3010);

        for (int i = 0; i < 4000; i++) begin
            logic            rv, rb, rp, ra;
            logic [XLEN-1:0] rpg, rag, rpc_in;
            rv     = ($urandom % 8) != 0;
            rb     = ($urandom % 4) != 0;
            rp     = $urandom % 2;
            ra     = $urandom % 2;
            rag    = $urandom & ~32'h3;
            rpg    = ($urandom % 2) ? rag : ($urandom & ~32'h3);
            rpc_in = ($urandom % 64 == 0) ? 32'hFFFF_FFFC : ($urandom & ~32'h3);
            step("random", rv, rb, rp, rpg, ra, rag, rpc_in);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule